// File: doc/BRIEF.md
# Analog-Shared General-Purpose I/O Port

This block is the register file and drive logic for a 16-pin general-purpose I/O port whose pins also serve as analog converter inputs. Software reaches it through a small byte-wide bus. It can write a data value, a direction and a digital-input-enable for every pin, and it can read back a per-pin mix of stored data, live pin levels or a fixed 1.

Each pin has three bits. The direction bit selects whether the pin is driven. The data bit holds the level to drive. The input-enable bit decides whether the pin's digital input buffer is on.

Each pin gets an output-enable and an output level for its pad. The synchronised input levels come back through a two-stage synchroniser. When a pin is an input with its buffer off, it is in analog use and reads as a constant 1. Out of reset every pin is in this state.

Top module: `analog_gpio_port`

## Requirements
- R1: While reset is asserted and right after it, every direction, input-enable and data bit is 0. As a result `padOutEn` and `padOutVal` are all 0, and reading either data byte returns 0xFF.
- R2: A write to a data byte always updates the stored bits, whatever the pin directions. `padOutVal` shows the written byte from the clock edge that takes the write.
- R3: `padOutEn` of each pin equals its direction bit. A data value written while the pin was an input is driven as soon as the direction is set to output.
- R4: Writing a data bit of an input pin leaves that pin undriven: `padOutEn` stays 0 for it.
- R5: For an output pin, reading its data bit returns the stored bit, not the pin level.
- R6: For an input pin whose input-enable bit is 0, reading its data bit returns 1.
- R7: For an input pin whose input-enable bit is 1, reading its data bit returns the pin level after two clock edges of synchronisation. After only one edge it still returns the earlier level.
- R8: The register map uses address bits [2:1] to pick the register (0 data, 1 direction, 2 input-enable) and bit 0 to pick the byte. Bit 0 = 0 selects pins 15..8 and bit 0 = 1 selects pins 7..0. Bit 7 of a byte is the highest pin of that byte, and a write to one byte leaves the other unchanged.
- R9: The direction and input-enable registers read back exactly what was last written to them.
- R10: Addresses 6 and 7 read as 0, and writes to them change no register or output.
- R11: Read data is combinational: it is valid in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register and byte select |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data |
| padIn | input | 16 | Pin input levels (asynchronous) |
| padOutEn | output | 16 | Per-pin drive enable |
| padOutVal | output | 16 | Per-pin drive level |

## Verification
A wrong direction bit shows on `padOutEn` one edge after the write that set it. A wrong data bit shows on `padOutVal` at that same edge, whether or not the pin is driven. A wrong input-enable bit, a swapped byte select or a broken read multiplexer shows only on `busRdData`, within the cycle the affected address is presented. Directed reads therefore cover every combination of direction and input-enable. A synchroniser with the wrong depth shows up as a read whose value changes one edge too early or too late after `padIn` moves.

// File: rtl/analog_gpio_pkg.sv
package analog_gpio_pkg;
  localparam int PORT_BYTES = 2;
  localparam int BYTE_BITS  = 8;
  localparam int PIN_COUNT  = PORT_BYTES * BYTE_BITS;
  localparam int BYTE_IDX_W = (PORT_BYTES > 1) ? $clog2(PORT_BYTES) : 1;
  localparam int ADDR_W     = 2 + BYTE_IDX_W;

  typedef enum logic [1:0] {
    SEL_DAT  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [PORT_BYTES-1:0] datWr;
    logic [PORT_BYTES-1:0] dirWr;
    logic [PORT_BYTES-1:0] ienWr;
    regSel_e               rdSel;
    logic [BYTE_IDX_W-1:0] rdByte;
  } ctrlStrobes_t;
endpackage

// File: rtl/analog_gpio_ctrl.sv
module analog_gpio_ctrl
  import analog_gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobes_t      strobes
);
  logic [1:0]            groupField;
  logic [BYTE_IDX_W-1:0] offsetField;
  logic                  offsetOk;
  regSel_e               sel;
  logic [BYTE_IDX_W-1:0] byteIdx;
  logic [PORT_BYTES-1:0] byteHot;

  assign groupField  = busAddr[ADDR_W-1 -: 2];
  assign offsetField = busAddr[BYTE_IDX_W-1:0];
  // offset 0 addresses the highest byte
  assign offsetOk    = (int'(offsetField) < PORT_BYTES);
  assign byteIdx     = BYTE_IDX_W'(PORT_BYTES - 1 - int'(offsetField));

  always_comb begin
    case (groupField)
      2'd0:    sel = SEL_DAT;
      2'd1:    sel = SEL_DIR;
      2'd2:    sel = SEL_IEN;
      default: sel = SEL_NONE;
    endcase
    if (!offsetOk) sel = SEL_NONE;
  end

  always_comb begin
    byteHot = '0;
    for (int b = 0; b < PORT_BYTES; b++) begin
      byteHot[b] = busWrEn && (int'(byteIdx) == b);
    end
  end

  assign strobes.datWr  = (sel == SEL_DAT) ? byteHot : '0;
  assign strobes.dirWr  = (sel == SEL_DIR) ? byteHot : '0;
  assign strobes.ienWr  = (sel == SEL_IEN) ? byteHot : '0;
  assign strobes.rdSel  = sel;
  assign strobes.rdByte = byteIdx;
endmodule

// File: rtl/analog_gpio_datapath.sv
module analog_gpio_datapath
  import analog_gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [BYTE_BITS-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [BYTE_BITS-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOutEn,
  output logic [PIN_COUNT-1:0] padOutVal
);
  logic [PIN_COUNT-1:0] datReg;
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] ienReg;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] pinSeen;
  logic [PIN_COUNT-1:0] dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      datReg <= '0;
      dirReg <= '0;
      ienReg <= '0;
    end else begin
      for (int b = 0; b < PORT_BYTES; b++) begin
        if (strobes.datWr[b]) datReg[b*BYTE_BITS +: BYTE_BITS] <= wrData;
        if (strobes.dirWr[b]) dirReg[b*BYTE_BITS +: BYTE_BITS] <= wrData;
        if (strobes.ienWr[b]) ienReg[b*BYTE_BITS +: BYTE_BITS] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  assign pinSeen = syncStage[SYNC_STAGES-1];

  genvar p;
  generate
    for (p = 0; p < PIN_COUNT; p++) begin : g_pinView
      always_comb begin
        if (dirReg[p])      dataView[p] = datReg[p];
        else if (ienReg[p]) dataView[p] = pinSeen[p];
        else                dataView[p] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    case (strobes.rdSel)
      SEL_DAT: rdData = dataView[int'(strobes.rdByte)*BYTE_BITS +: BYTE_BITS];
      SEL_DIR: rdData = dirReg[int'(strobes.rdByte)*BYTE_BITS +: BYTE_BITS];
      SEL_IEN: rdData = ienReg[int'(strobes.rdByte)*BYTE_BITS +: BYTE_BITS];
      default: rdData = '0;
    endcase
  end

  assign padOutEn  = dirReg;
  assign padOutVal = datReg;
endmodule

// File: rtl/analog_gpio_port.sv
module analog_gpio_port
  import analog_gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BYTE_BITS-1:0] busWrData,
  output logic [BYTE_BITS-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOutEn,
  output logic [PIN_COUNT-1:0] padOutVal
);
  ctrlStrobes_t strobes;

  analog_gpio_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  analog_gpio_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (busWrData),
    .padIn     (padIn),
    .rdData    (busRdData),
    .padOutEn  (padOutEn),
    .padOutVal (padOutVal)
  );
endmodule

// File: rtl/analog_gpio_port_chk.sv
module analog_gpio_port_chk
  import analog_gpio_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [BYTE_BITS-1:0] busWrData,
  input logic [BYTE_BITS-1:0] busRdData,
  input logic [PIN_COUNT-1:0] padOutEn,
  input logic [PIN_COUNT-1:0] padOutVal
);
  // R1: reset clears the drive outputs
  p_reset_clears_r1: assert property (@(posedge clk)
    !rstN |=> (padOutEn == '0 && padOutVal == '0));

  // R2: a low data byte write appears on padOutVal at the next edge
  p_data_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd1) |=> padOutVal[7:0] == $past(busWrData));

  // R3: an upper direction byte write sets padOutEn
  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd2) |=> padOutEn[15:8] == $past(busWrData));

  // R8: a lower direction byte write leaves the upper byte alone
  p_byte_isolate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd3) |=> $stable(padOutEn[15:8]));

  // R10: the unused addresses read as zero
  p_unused_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[2:1] == 2'b11) |-> busRdData == '0);

  // R10: no write strobe means no drive change
  p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn || busAddr[2:1] == 2'b11) |=> ($stable(padOutEn) && $stable(padOutVal)));
endmodule

bind analog_gpio_port analog_gpio_port_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padOutEn  (padOutEn),
  .padOutVal (padOutVal)
);

// File: tb/analog_gpio_port_test.sv
`timescale 1ns/1ps
module analog_gpio_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [15:0] padIn = '0;
  logic [15:0] padOutEn;
  logic [15:0] padOutVal;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_DAT_HI = 3'd0, A_DAT_LO = 3'd1, A_DIR_HI = 3'd2,
                         A_DIR_LO = 3'd3, A_IEN_HI = 3'd4, A_IEN_LO = 3'd5;

  always #10 clk = ~clk;

  analog_gpio_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOutEn(padOutEn), .padOutVal(padOutVal)
  );

  task automatic expect16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(string tag, logic [2:0] a, logic [7:0] exp);
    busAddr = a;
    #1;
    expect16(tag, {8'h00, busRdData}, {8'h00, exp});
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    expect16("R1 oe", padOutEn, 16'h0000);
    expect16("R1 val", padOutVal, 16'h0000);
    readCheck("R1 dat hi", A_DAT_HI, 8'hFF);
    readCheck("R1 dat lo", A_DAT_LO, 8'hFF);
    readCheck("R1 dir lo", A_DIR_LO, 8'h00);
    readCheck("R1 ien hi", A_IEN_HI, 8'h00);
  endtask

  task automatic testLatentData();
    writeReg(A_DAT_LO, 8'hA5);
    expect16("R4 oe stays off", padOutEn, 16'h0000);
    expect16("R2 stored val", padOutVal, 16'h00A5);
    readCheck("R6 analog reads 1", A_DAT_LO, 8'hFF);
    writeReg(A_DIR_LO, 8'hFF);
    expect16("R3 oe on", padOutEn, 16'h00FF);
    expect16("R3 val driven", padOutVal, 16'h00A5);
    padIn = 16'h005A;
    @(negedge clk); @(negedge clk);
    readCheck("R5 output reads latch", A_DAT_LO, 8'hA5);
  endtask

  task automatic testSyncInput();
    writeReg(A_DIR_LO, 8'h00);
    writeReg(A_IEN_LO, 8'hFF);
    readCheck("R7 old level", A_DAT_LO, 8'h5A);
    padIn = 16'h003C;
    @(negedge clk);
    readCheck("R7 one edge", A_DAT_LO, 8'h5A);
    @(negedge clk);
    readCheck("R7 two edges", A_DAT_LO, 8'h3C);
  endtask

  task automatic testMixedBits();
    writeReg(A_DIR_LO, 8'hF0);
    writeReg(A_IEN_LO, 8'h0C);
    padIn = 16'h0000;
    @(negedge clk); @(negedge clk);
    readCheck("R11 mixed view", A_DAT_LO, 8'hA3);
    readCheck("R9 dir lo", A_DIR_LO, 8'hF0);
    readCheck("R9 ien lo", A_IEN_LO, 8'h0C);
  endtask

  task automatic testUpperByte();
    writeReg(A_DIR_HI, 8'h81);
    writeReg(A_DAT_HI, 8'h80);
    expect16("R8 oe", padOutEn, 16'h81F0);
    expect16("R8 val", padOutVal, 16'h80A5);
    readCheck("R8 dat hi", A_DAT_HI, 8'hFE);
    readCheck("R8 dat lo kept", A_DAT_LO, 8'hA3);
  endtask

  task automatic testUnused();
    writeReg(3'd6, 8'hFF);
    writeReg(3'd7, 8'h00);
    readCheck("R10 addr6", 3'd6, 8'h00);
    readCheck("R10 addr7", 3'd7, 8'h00);
    expect16("R10 oe kept", padOutEn, 16'h81F0);
    expect16("R10 val kept", padOutVal, 16'h80A5);
    readCheck("R10 ien hi kept", A_IEN_HI, 8'h00);
  endtask

  initial begin
    applyReset();
    testReset();
    testLatentData();
    testSyncInput();
    testMixedBits();
    testUpperByte();
    testUnused();
    applyReset();
    testReset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule